// File: doc/BRIEF.md
# DMA Address Translation Unit

This block turns device DMA addresses into physical addresses using a single-level translation table that lives in system memory. Software programs a 64-bit control word and a 64-bit table base through a small register port. A translation request arrives on a valid/ready port. The block works out where the matching table entry sits, fetches that 64-bit entry with one read on a memory request/response port, and returns a physical address, a permission code and a fault flag.

The control word decides how the table is indexed. One bit turns translation on or off. A second bit picks the granule the table is indexed by, either 8 KiB or 64 KiB. A 3-bit size code picks how many address bits form the index. Each entry also carries its own page-size bit, which decides how much of the incoming address is kept as the in-page offset. Only one table read is in flight at a time. A flush register is decoded, but writing it has no effect.

Top module: `dma_xlate_unit`

## Requirements
- R1: While reset is asserted and right after it: `req_ready` is 1, `mem_req_valid` and `rsp_valid` are 0, and both the control word and the base read back as 0.
- R2: The register byte offset `reg_addr[4:2]` selects the register: 0 is control, 2 is base. A 64-bit access (`reg_wide`=1) at offset 0x0 or 0x8 reads or writes the whole register. A 32-bit access at 0x0 or 0x8 reaches bits 63:32. A 32-bit access at 0x4 or 0xC reaches bits 31:0. Narrow data travels in bits 31:0 of the data buses, and narrow reads return zero in bits 63:32.
- R3: Offsets 0x10 and 0x14 (flush) read as zero. Writes there leave both the control word and the base unchanged.
- R4: When control bit 0 is clear, the result is the request address zero-extended to 41 bits, with permission 2'b11 (read-write) and no fault. No memory read is issued, and `rsp_valid` is high in the cycle after the request is accepted.
- R5: When control bit 0 is set and control bit 2 is clear, size code n = control bits 18:16 (0 to 7) makes the entry address equal to base + 8 × address bits [22+n:13].
- R6: When control bits 0 and 2 are both set, size code n from 0 to 5 makes the entry address equal to base + 8 × address bits [25+n:16].
- R7: With control bits 0 and 2 set and size code 6 or 7, the result is a fault with permission 2'b00 and physical address 0. No memory read is issued, and `rsp_valid` is high in the cycle after the request is accepted.
- R8: The entry is read big-endian. Memory lane k (`mem_rsp_data[8k+7:8k]`) holds the byte at entry address + k, and the byte at the lowest address is the most significant byte of the entry.
- R9: If entry bit 63 is clear, the result is a fault with permission 2'b00 and physical address 0.
- R10: For a valid entry, entry bit 1 set gives permission 2'b11 (read-write). Entry bit 1 clear gives 2'b01 (read-only). The fault flag is 0 in both cases.
- R11: For a valid entry with bit 61 set, the physical address is entry bits 40:15 (kept at their own positions) ORed with address bits 15:0. With bit 61 clear, it is entry bits 40:13 ORed with address bits 12:0.
- R12: Only one translation is outstanding. `req_ready` is low from acceptance until the result. `mem_req_valid` stays high with a stable address until `mem_req_ready`. `rsp_valid` rises in the cycle after the edge that samples `mem_rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr`/`reg_wide` |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Ready to accept a translation |
| req_addr | input | 32 | Device DMA address |
| mem_req_valid | output | 1 | Table entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Table entry byte address |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Entry bytes in address-lane order |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_pa | output | 41 | Physical address |
| rsp_perm | output | 2 | 00 none, 01 read-only, 11 read-write |
| rsp_fault | output | 1 | Translation fault |

## Verification
Results that need no table read (translation off, or a bad 64 KiB size code) are due in the cycle right after the accepting edge. The driver samples `rsp_valid` at the next falling edge, and at that same edge it confirms that no memory read appeared. For table walks, the memory model stalls `mem_req_ready` for one cycle. It checks the entry address when it grants the read, returns the byte-lane-ordered entry two cycles later, and expects `rsp_valid` at the falling edge after the edge that sampled `mem_rsp_valid`. While the walk is in progress, the driver checks that `req_ready` is low. A scoreboard queue holds the expected address, permission and fault for every request, and a monitor pops an entry each time `rsp_valid` is seen.

// File: rtl/dxu_pkg.sv
package dxu_pkg;

  // control word layout
  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_BIG_BIT = 2;
  localparam int CTL_CODE_LO = 16;
  localparam int CODE_W      = 3;
  localparam int NCODES      = 1 << CODE_W;

  // table entry layout
  localparam int ENT_V_BIT  = 63;
  localparam int ENT_SZ_BIT = 61;
  localparam int ENT_WR_BIT = 1;

  typedef enum logic [1:0] {
    PERM_NONE = 2'b00,
    PERM_RO   = 2'b01,
    PERM_RW   = 2'b11
  } perm_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MREQ  = 2'd1,
    ST_MWAIT = 2'd2
  } xst_e;

  typedef struct packed {
    logic              en;
    logic              big;
    logic [CODE_W-1:0] code;
  } xcfg_t;

endpackage

// File: rtl/dxu_regs.sv
module dxu_regs
  import dxu_pkg::*;
#(
  parameter int REG_W  = 64,
  parameter int OFF_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [OFF_W-1:0] addr,
  input  logic             wide,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic [REG_W-1:0] ctl_q,
  output logic [REG_W-1:0] base_q
);

  localparam int HALF  = REG_W / 2;
  localparam int SEL_W = OFF_W - 2;

  localparam logic [SEL_W-1:0] SEL_CTL_HI  = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_CTL_LO  = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_BASE_HI = SEL_W'(2);
  localparam logic [SEL_W-1:0] SEL_BASE_LO = SEL_W'(3);

  logic [SEL_W-1:0] sel;
  logic [REG_W-1:0] ctl_d, base_d;
  logic             ctl_en, base_en;
  logic [1:0]       unused_addr;

  assign sel         = addr[OFF_W-1:2];
  assign unused_addr = addr[1:0];

  // next-state for writes
  always_comb begin
    ctl_d   = ctl_q;
    base_d  = base_q;
    ctl_en  = 1'b0;
    base_en = 1'b0;
    if (wr) begin
      unique case (sel)
        SEL_CTL_HI: begin
          ctl_en = 1'b1;
          ctl_d  = wide ? wdata : {wdata[HALF-1:0], ctl_q[HALF-1:0]};
        end
        SEL_CTL_LO: begin
          ctl_en = 1'b1;
          ctl_d  = {ctl_q[REG_W-1:HALF], wdata[HALF-1:0]};
        end
        SEL_BASE_HI: begin
          base_en = 1'b1;
          base_d  = wide ? wdata : {wdata[HALF-1:0], base_q[HALF-1:0]};
        end
        SEL_BASE_LO: begin
          base_en = 1'b1;
          base_d  = {base_q[REG_W-1:HALF], wdata[HALF-1:0]};
        end
        default: ;  // flush and unmapped offsets: no state change
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      base_q <= '0;
    end else begin
      if (ctl_en)  ctl_q  <= ctl_d;
      if (base_en) base_q <= base_d;
    end
  end

  // read decode
  always_comb begin
    unique case (sel)
      SEL_CTL_HI:  rdata = wide ? ctl_q  : {{HALF{1'b0}}, ctl_q[REG_W-1:HALF]};
      SEL_CTL_LO:  rdata = {{HALF{1'b0}}, ctl_q[HALF-1:0]};
      SEL_BASE_HI: rdata = wide ? base_q : {{HALF{1'b0}}, base_q[REG_W-1:HALF]};
      SEL_BASE_LO: rdata = {{HALF{1'b0}}, base_q[HALF-1:0]};
      default:     rdata = '0;
    endcase
  end

  // R3: flush / unmapped writes leave both registers alone
  assert_flush_inert_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel > SEL_BASE_LO) |=> ($stable(ctl_q) && $stable(base_q)));

endmodule

// File: rtl/dxu_index.sv
module dxu_index
  import dxu_pkg::*;
#(
  parameter int DVA_W       = 32,
  parameter int MA_W        = 64,
  parameter int SMALL_SHIFT = 13,
  parameter int LARGE_SHIFT = 16,
  parameter int IDX_MIN_W   = 10,
  parameter int LARGE_CODES = 6,
  parameter int ENT_LG      = 3
) (
  input  logic [DVA_W-1:0] dva,
  input  xcfg_t            cfg,
  input  logic [MA_W-1:0]  base,
  output logic [MA_W-1:0]  ent_addr,
  output logic             code_bad
);

  logic [MA_W-1:0] off_small [NCODES];
  logic [MA_W-1:0] off_large [NCODES];
  logic [MA_W-1:0] offset;
  logic            unused_dva;

  // one candidate index per size code and granule
  for (genvar c = 0; c < NCODES; c++) begin : g_code
    localparam int IW = IDX_MIN_W + c;
    assign off_small[c] = MA_W'(dva[SMALL_SHIFT +: IW]) << ENT_LG;
    if (c < LARGE_CODES) begin : g_large
      assign off_large[c] = MA_W'(dva[LARGE_SHIFT +: IW]) << ENT_LG;
    end else begin : g_none
      assign off_large[c] = '0;
    end
  end

  assign code_bad   = cfg.big && (cfg.code >= CODE_W'(LARGE_CODES));
  assign offset     = cfg.big ? off_large[cfg.code] : off_small[cfg.code];
  assign ent_addr   = base + offset;
  assign unused_dva = ^dva;

endmodule

// File: rtl/dxu_engine.sv
module dxu_engine
  import dxu_pkg::*;
#(
  parameter int DVA_W       = 32,
  parameter int MA_W        = 64,
  parameter int PA_W        = 41,
  parameter int DATA_W      = 64,
  parameter int SMALL_SHIFT = 13,
  parameter int LARGE_SHIFT = 16,
  parameter int LFRAME_LO   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  xcfg_t             cfg,
  input  logic              code_bad,
  input  logic [MA_W-1:0]   ent_addr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DVA_W-1:0]  req_addr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [MA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [1:0]        rsp_perm,
  output logic              rsp_fault
);

  localparam int NBYTES = DATA_W / 8;

  xst_e                   st_q, st_d;
  logic [MA_W-1:0]        maddr_q, maddr_d;
  logic                   maddr_en;
  logic [LARGE_SHIFT-1:0] off_q, off_d;
  logic                   off_en;
  logic                   rv_q, rv_d;
  logic [PA_W-1:0]        pa_q, pa_d;
  perm_e                  perm_q, perm_d;
  logic                   fault_q, fault_d;
  logic                   res_en;
  logic [DATA_W-1:0]      entry;
  logic [PA_W-1:0]        frame_s, frame_l, pa_s, pa_l;
  logic                   unused_ent;

  // big-endian entry: lowest-address lane is the most significant byte
  always_comb begin
    for (int k = 0; k < NBYTES; k++) begin
      entry[8*k +: 8] = mem_rsp_data[DATA_W-8-8*k +: 8];
    end
  end

  assign frame_s    = {entry[PA_W-1:SMALL_SHIFT], {SMALL_SHIFT{1'b0}}};
  assign frame_l    = {entry[PA_W-1:LFRAME_LO], {LFRAME_LO{1'b0}}};
  assign pa_s       = frame_s | PA_W'(off_q[SMALL_SHIFT-1:0]);
  assign pa_l       = frame_l | PA_W'(off_q);
  assign unused_ent = ^entry;

  // next-state
  always_comb begin
    st_d     = st_q;
    maddr_d  = maddr_q;
    maddr_en = 1'b0;
    off_d    = off_q;
    off_en   = 1'b0;
    rv_d     = 1'b0;
    res_en   = 1'b0;
    pa_d     = pa_q;
    perm_d   = perm_q;
    fault_d  = fault_q;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          off_en = 1'b1;
          off_d  = req_addr[LARGE_SHIFT-1:0];
          if (!cfg.en) begin
            res_en  = 1'b1;
            rv_d    = 1'b1;
            pa_d    = PA_W'(req_addr);
            perm_d  = PERM_RW;
            fault_d = 1'b0;
          end else if (code_bad) begin
            res_en  = 1'b1;
            rv_d    = 1'b1;
            pa_d    = '0;
            perm_d  = PERM_NONE;
            fault_d = 1'b1;
          end else begin
            st_d     = ST_MREQ;
            maddr_en = 1'b1;
            maddr_d  = ent_addr;
          end
        end
      end
      ST_MREQ: begin
        if (mem_req_ready) st_d = ST_MWAIT;
      end
      ST_MWAIT: begin
        if (mem_rsp_valid) begin
          st_d   = ST_IDLE;
          res_en = 1'b1;
          rv_d   = 1'b1;
          if (!entry[ENT_V_BIT]) begin
            pa_d    = '0;
            perm_d  = PERM_NONE;
            fault_d = 1'b1;
          end else begin
            fault_d = 1'b0;
            perm_d  = entry[ENT_WR_BIT] ? PERM_RW : PERM_RO;
            pa_d    = entry[ENT_SZ_BIT] ? pa_l : pa_s;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      maddr_q <= '0;
      off_q   <= '0;
      rv_q    <= 1'b0;
      pa_q    <= '0;
      perm_q  <= PERM_NONE;
      fault_q <= 1'b0;
    end else begin
      st_q <= st_d;
      rv_q <= rv_d;
      if (maddr_en) maddr_q <= maddr_d;
      if (off_en)   off_q   <= off_d;
      if (res_en) begin
        pa_q    <= pa_d;
        perm_q  <= perm_d;
        fault_q <= fault_d;
      end
    end
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign mem_req_valid = (st_q == ST_MREQ);
  assign mem_req_addr  = maddr_q;
  assign rsp_valid     = rv_q;
  assign rsp_pa        = pa_q;
  assign rsp_perm      = perm_q;
  assign rsp_fault     = fault_q;

  // R12: a stalled table read holds its request and address
  assert_hold_mreq_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R4: translation off answers in the next cycle with read-write
  assert_bypass_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !cfg.en) |=> (rsp_valid && !rsp_fault && rsp_perm == PERM_RW));

  // R7: invalid 64K size code faults in the next cycle without a table read
  assert_badcode_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && cfg.en && cfg.big && cfg.code >= 3'd6)
      |=> (rsp_valid && rsp_fault && !mem_req_valid));

  // R9: a fault never carries a permission
  assert_fault_noperm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_perm == PERM_NONE && rsp_pa == '0));

endmodule

// File: rtl/dma_xlate_unit.sv
module dma_xlate_unit
  import dxu_pkg::*;
#(
  parameter int DVA_W       = 32,
  parameter int MA_W        = 64,
  parameter int PA_W        = 41,
  parameter int REG_W       = 64,
  parameter int OFF_W       = 5,
  parameter int SMALL_SHIFT = 13,
  parameter int LARGE_SHIFT = 16,
  parameter int LFRAME_LO   = 15,
  parameter int IDX_MIN_W   = 10,
  parameter int LARGE_CODES = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [OFF_W-1:0] reg_addr,
  input  logic             reg_wide,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [DVA_W-1:0] req_addr,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [MA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [REG_W-1:0] mem_rsp_data,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_pa,
  output logic [1:0]       rsp_perm,
  output logic             rsp_fault
);

  localparam int ENT_LG = $clog2(REG_W / 8);

  logic [1:0]       rst_sync;
  logic             rst_in_n;
  logic [REG_W-1:0] ctl_q, base_q;
  logic [MA_W-1:0]  ent_addr;
  logic             code_bad;
  xcfg_t            cfg;
  logic             unused_ctl;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_in_n = rst_sync[1];

  assign cfg.en     = ctl_q[CTL_EN_BIT];
  assign cfg.big    = ctl_q[CTL_BIG_BIT];
  assign cfg.code   = ctl_q[CTL_CODE_LO +: CODE_W];
  assign unused_ctl = ^ctl_q;

  dxu_regs #(
    .REG_W (REG_W),
    .OFF_W (OFF_W)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_in_n),
    .wr     (reg_wr),
    .addr   (reg_addr),
    .wide   (reg_wide),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .ctl_q  (ctl_q),
    .base_q (base_q)
  );

  dxu_index #(
    .DVA_W       (DVA_W),
    .MA_W        (MA_W),
    .SMALL_SHIFT (SMALL_SHIFT),
    .LARGE_SHIFT (LARGE_SHIFT),
    .IDX_MIN_W   (IDX_MIN_W),
    .LARGE_CODES (LARGE_CODES),
    .ENT_LG      (ENT_LG)
  ) u_index (
    .dva      (req_addr),
    .cfg      (cfg),
    .base     (MA_W'(base_q)),
    .ent_addr (ent_addr),
    .code_bad (code_bad)
  );

  dxu_engine #(
    .DVA_W       (DVA_W),
    .MA_W        (MA_W),
    .PA_W        (PA_W),
    .DATA_W      (REG_W),
    .SMALL_SHIFT (SMALL_SHIFT),
    .LARGE_SHIFT (LARGE_SHIFT),
    .LFRAME_LO   (LFRAME_LO)
  ) u_engine (
    .clk           (clk),
    .rst_n         (rst_in_n),
    .cfg           (cfg),
    .code_bad      (code_bad),
    .ent_addr      (ent_addr),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_addr      (req_addr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .rsp_valid     (rsp_valid),
    .rsp_pa        (rsp_pa),
    .rsp_perm      (rsp_perm),
    .rsp_fault     (rsp_fault)
  );

  // R1: nothing is requested or answered while held in reset
  assert_quiet_reset_R1: assert property (@(posedge clk)
    (!rst_in_n) |-> (!mem_req_valid && !rsp_valid && req_ready));

endmodule

// File: tb/dma_xlate_unit_bench.sv
`timescale 1ns/1ps
module dma_xlate_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [4:0]  reg_addr;
  logic        reg_wide;
  logic [63:0] reg_wdata;
  logic [63:0] reg_rdata;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        rsp_valid;
  logic [40:0] rsp_pa;
  logic [1:0]  rsp_perm;
  logic        rsp_fault;

  always #4 clk = ~clk;  // 125 MHz

  dma_xlate_unit u_dma_xlate_unit (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wide(reg_wide),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
    .rsp_perm(rsp_perm), .rsp_fault(rsp_fault)
  );

  typedef struct {
    logic [40:0] pa;
    logic [1:0]  perm;
    logic        fault;
    string       tag;
  } exp_t;

  typedef struct {
    logic [63:0] addr;
    logic [63:0] ent;
    string       tag;
  } mexp_t;

  exp_t  exp_q[$];
  mexp_t mem_q[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  int    n_rsp  = 0;
  bit    ended  = 0;
  logic [63:0] base;

  task automatic chk(input logic ok, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // scoreboard monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R12 result with nothing outstanding", 64'(rsp_pa), 64'd0);
        end else begin
          e = exp_q.pop_front();
          chk(rsp_pa == e.pa, {e.tag, " pa"}, 64'(rsp_pa), 64'(e.pa));
          chk(rsp_perm == e.perm, {e.tag, " perm"}, 64'(rsp_perm), 64'(e.perm));
          chk(rsp_fault == e.fault, {e.tag, " fault"}, 64'(rsp_fault), 64'(e.fault));
        end
        n_rsp++;
      end
    end
  end

  // memory model; R8: byte at entry address + k travels on lane k
  initial begin
    mexp_t m;
    logic [63:0] cur_ent = '0;
    int wait_cnt = 0;
    bit stalled = 0;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (mem_rsp_valid) begin
        mem_rsp_valid = 1'b0;
        chk(rsp_valid == 1'b1, "R12 result one cycle after entry data",
            64'(rsp_valid), 64'd1);
      end
      if (wait_cnt > 0) begin
        wait_cnt--;
        if (wait_cnt == 0) begin
          for (int k = 0; k < 8; k++) mem_rsp_data[8*k +: 8] = cur_ent[56-8*k +: 8];
          mem_rsp_valid = 1'b1;
        end
      end
      if (mem_req_ready) begin
        mem_req_ready = 1'b0;
        wait_cnt = 2;
      end else if (mem_req_valid && wait_cnt == 0 && !mem_rsp_valid) begin
        if (!stalled) begin
          stalled = 1;
        end else begin
          stalled = 0;
          if (mem_q.size() == 0) begin
            chk(1'b0, "R4/R7 unexpected table read (R4 R7)", mem_req_addr, 64'd0);
          end else begin
            m = mem_q.pop_front();
            chk(mem_req_addr == m.addr, {m.tag, " entry address"}, mem_req_addr, m.addr);
            cur_ent = m.ent;
          end
          mem_req_ready = 1'b1;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'd0, 64'd1);
    finish_run();
  end

  task automatic reg_write(input logic [4:0] a, input logic w, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wide = w; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_check(input logic [4:0] a, input logic w,
                           input logic [63:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a; reg_wide = w;
    #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  function automatic logic [63:0] tbl_addr(input logic [63:0] b, input logic [31:0] dva,
                                           input bit big, input int code);
    int lo = big ? 16 : 13;
    int w  = 10 + code;
    return b + ((((64'(dva)) >> lo) & ((64'd1 << w) - 1)) << 3);
  endfunction

  task automatic drive(input logic [31:0] dva, input bit uses_mem, input string tag);
    int target = n_rsp + 1;
    @(negedge clk);
    chk(req_ready == 1'b1, {tag, " R12 ready when idle"}, 64'(req_ready), 64'd1);
    req_addr = dva; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (!uses_mem)
      chk(rsp_valid == 1'b1, {tag, " result one cycle after accept"}, 64'(rsp_valid), 64'd1);
    else
      chk(req_ready == 1'b0, {tag, " R12 busy during walk"}, 64'(req_ready), 64'd0);
    while (n_rsp < target) @(negedge clk);
  endtask

  task automatic xlate_direct(input logic [31:0] dva, input logic [40:0] pa,
                              input logic [1:0] perm, input logic fault, input string tag);
    exp_t e;
    e.pa = pa; e.perm = perm; e.fault = fault; e.tag = tag;
    exp_q.push_back(e);
    drive(dva, 0, tag);
  endtask

  task automatic xlate_table(input logic [31:0] dva, input logic [63:0] maddr,
                             input logic [63:0] ent, input string tag);
    exp_t  e;
    mexp_t m;
    logic [63:0] pa64;
    if (!ent[63]) begin
      e.pa = '0; e.perm = 2'b00; e.fault = 1'b1;
    end else begin
      e.fault = 1'b0;
      e.perm  = ent[1] ? 2'b11 : 2'b01;
      if (ent[61]) pa64 = (ent & 64'h1ff_ffff_8000) | {48'd0, dva[15:0]};
      else         pa64 = (ent & 64'h1ff_ffff_e000) | {51'd0, dva[12:0]};
      e.pa = pa64[40:0];
    end
    e.tag = tag;
    m.addr = maddr; m.ent = ent; m.tag = tag;
    exp_q.push_back(e);
    mem_q.push_back(m);
    drive(dva, 1, tag);
  endtask

  initial begin
    logic [63:0] ctl;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wide = 1'b1; reg_wdata = '0;
    req_valid = 1'b0; req_addr = '0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 req_ready in reset", 64'(req_ready), 64'd1);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid in reset", 64'(mem_req_valid), 64'd0);
    chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    reg_check(5'h00, 1, 64'd0, "R1 control after reset");
    reg_check(5'h08, 1, 64'd0, "R1 base after reset");

    // R2 register halves
    reg_write(5'h08, 1, 64'h0000_0012_3456_0000);
    reg_check(5'h08, 1, 64'h0000_0012_3456_0000, "R2 base wide read");
    reg_check(5'h08, 0, 64'h0000_0000_0000_0012, "R2 base upper half");
    reg_check(5'h0C, 0, 64'h0000_0000_3456_0000, "R2 base lower half");
    reg_write(5'h08, 0, 64'hFFFF_FFFF_0000_0001);
    reg_check(5'h08, 1, 64'h0000_0001_3456_0000, "R2 narrow write upper");
    reg_write(5'h0C, 0, 64'h0000_0000_0010_0000);
    reg_check(5'h08, 1, 64'h0000_0001_0010_0000, "R2 narrow write lower");
    base = 64'h0000_0001_0010_0000;
    reg_write(5'h00, 0, 64'h0000_0000_AAAA_5555);
    reg_check(5'h00, 1, 64'hAAAA_5555_0000_0000, "R2 control upper write");
    reg_check(5'h04, 0, 64'h0000_0000_0000_0000, "R2 control lower half");
    reg_write(5'h00, 1, 64'd0);

    // R3 flush
    reg_write(5'h10, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    reg_write(5'h14, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    reg_check(5'h10, 1, 64'd0, "R3 flush reads zero");
    reg_check(5'h14, 0, 64'd0, "R3 flush lower reads zero");
    reg_check(5'h08, 1, base, "R3 base untouched by flush");
    reg_check(5'h00, 1, 64'd0, "R3 control untouched by flush");

    // R4 pass-through
    xlate_direct(32'hDEAD_BEEF, 41'h0_DEAD_BEEF, 2'b11, 1'b0, "R4 bypass");
    reg_write(5'h00, 1, 64'h0000_0000_0007_0004);
    xlate_direct(32'h0000_1FFF, 41'h0_0000_1FFF, 2'b11, 1'b0, "R4 bypass with mode bits");

    // R5 8K indexing, R10 permissions
    ctl = 64'h1;
    reg_write(5'h00, 1, ctl);
    xlate_table(32'h1234_5678, tbl_addr(base, 32'h1234_5678, 0, 0),
                64'h8000_0123_4567_A002, "R5 code0 R10 read-write");
    ctl = 64'h0007_0001;
    reg_write(5'h00, 1, ctl);
    xlate_table(32'h3FFF_E123, tbl_addr(base, 32'h3FFF_E123, 0, 7),
                64'h8000_0000_0ABC_C000, "R5 code7 R10 read-only");
    ctl = 64'h0003_0001;
    reg_write(5'h00, 1, ctl);
    xlate_table(32'h0F0F_0F0F, tbl_addr(base, 32'h0F0F_0F0F, 0, 3),
                64'h7FFF_FFFF_FFFF_FFFF, "R9 invalid entry");

    // R6 64K indexing, R11 page size
    ctl = 64'h0000_0005;
    reg_write(5'h00, 1, ctl);
    xlate_table(32'h0123_4567, tbl_addr(base, 32'h0123_4567, 1, 0),
                64'hA000_01AB_CDEF_0002, "R6 code0 R11 large page");
    ctl = 64'h0005_0005;
    reg_write(5'h00, 1, ctl);
    xlate_table(32'h7FFF_FFFF, tbl_addr(base, 32'h7FFF_FFFF, 1, 5),
                64'hA000_0000_1234_8000, "R6 code5 R11 large page read-only");

    // R7 bad large codes
    reg_write(5'h00, 1, 64'h0006_0005);
    xlate_direct(32'h0000_4000, 41'd0, 2'b00, 1'b1, "R7 code6 fault");
    reg_write(5'h00, 1, 64'h0007_0005);
    xlate_direct(32'hFFFF_FFFF, 41'd0, 2'b00, 1'b1, "R7 code7 fault");

    // R11 large page in 8K table, R8 byte order
    reg_write(5'h00, 1, 64'h0000_0001);
    xlate_table(32'h0000_9ABC, tbl_addr(base, 32'h0000_9ABC, 0, 0),
                64'hA000_0055_5555_5002, "R11 large page in 8K table");
    reg_write(5'h00, 1, 64'h0002_0001);
    xlate_table(32'h00AB_CDEF, tbl_addr(base, 32'h00AB_CDEF, 0, 2),
                64'h8000_0102_0304_0506, "R8 byte order small page");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R12 all results delivered", 64'(exp_q.size()), 64'd0);
    finish_run();
  end

endmodule